// File: doc/BRIEF.md
# Filtered Clear-to-Send Change Detector

This block watches an asynchronous, active-low clear-to-send line. It presents the line's filtered level, together with a sticky change indication, in a read-only 8-bit status byte. The raw input first passes through a flop synchronizer. A change of level is accepted only after the new level has been seen on a set number of consecutive sample ticks. The sample ticks come from the serial clock. A shorter excursion is discarded.

An accepted change sets a sticky flag. Reading the status byte clears that flag. When the interrupt enable is set, the flag drives a level-sensitive interrupt request. After reset the line is sampled once, on the second sample tick. If the line is already asserted at that point, the flag is raised, so software sees that the modem is ready. When the modem-mode input is high, the flag is never set and no interrupt is raised.

Top module: `cts_cos_detector`

## Requirements
- R1: In the status byte, bits 7:5 always read 0 and bits 3:1 always read 1.
- R2: Status bit 0 is the accepted line level. It reads 0 when the line is asserted (low) and 1 when it is negated. It reads 1 from reset until the first sample.
- R3: A level that differs from the accepted one is accepted only after it has been seen on FILT_TICKS consecutive sample ticks (default 4). When it is accepted, bit 0 updates and status bit 4 (the change flag) is set. An excursion that returns before that count has no effect on either bit.
- R4: A one-cycle read strobe clears the change flag in the following cycle.
- R5: If an accepted change and a read strobe fall in the same cycle, the flag ends up set.
- R6: On the second sample tick after reset, bit 0 loads the synchronized level. If that level is asserted, the change flag is set. Earlier ticks do not change the status.
- R7: irq_o is high exactly while the change flag is set, the enable is high and modem mode is off. It drops as soon as any of these conditions fails.
- R8: While modem mode is high, neither an accepted change nor the startup sample sets the flag, and irq_o stays low. Bit 0 still tracks the line.
- R9: Status bit 0 changes only in the cycle after a sample tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle sample tick derived from the serial clock |
| cts_ni | input | 1 | Asynchronous clear-to-send line, active low |
| rd_i | input | 1 | Status read strobe, clears the change flag |
| irq_en_i | input | 1 | Interrupt enable for the change flag |
| modem_mode_i | input | 1 | Modem mode, disables change detection |
| status_o | output | 8 | Status byte: bit 4 change flag, bit 0 line level |
| irq_o | output | 1 | Level interrupt request |

## Verification
The filter is swept with excursions that last from one tick up to one tick more than the filter length, in both directions. This separates discarded glitches from accepted changes at the exact threshold. Startup is run with the line asserted and negated, and with modem mode on and off; this separates the startup flag from a normal transition. Tick-free waits and a read placed in the same cycle as an acceptance show that the level bit moves only on ticks, and that the set takes priority over the clear.

// File: rtl/cts_cos_pkg.sv
package cts_cos_pkg;
  localparam int unsigned STATUS_W  = 8;
  localparam int unsigned FLAG_BIT  = 4;
  localparam int unsigned LVL_BIT   = 0;
  localparam logic [2:0]  FILL_ONES = 3'b111;

  function automatic logic [STATUS_W-1:0] pack_status(input logic flag, input logic lvl);
    pack_status = {3'b000, flag, FILL_ONES, lvl};
  endfunction
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;  // idle = negated
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cts_filter.sv
module cts_filter #(
  parameter int unsigned FILT_TICKS = 4,
  parameter int unsigned BOOT_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lvl_i,
  output logic state_o,
  output logic set_req_o
);
  localparam int unsigned CW = $clog2(FILT_TICKS + 1);
  localparam int unsigned BW = $clog2(BOOT_TICKS + 1);

  logic          armed_q;
  logic [BW-1:0] boot_q;
  logic [CW-1:0] cnt_q;
  logic          state_q;
  logic          boot_hit, filt_hit;

  assign boot_hit = !armed_q && tick_i && (boot_q == BW'(BOOT_TICKS - 1));
  assign filt_hit = armed_q && tick_i && (lvl_i != state_q) && (cnt_q == CW'(FILT_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      boot_q  <= '0;
      cnt_q   <= '0;
      state_q <= 1'b1;
    end else if (!armed_q) begin
      if (tick_i) begin
        if (boot_hit) begin
          armed_q <= 1'b1;
          state_q <= lvl_i;
        end else begin
          boot_q <= boot_q + 1'b1;
        end
      end
    end else if (lvl_i == state_q) begin
      cnt_q <= '0;  // reload while level matches
    end else if (tick_i) begin
      if (filt_hit) begin
        state_q <= lvl_i;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign state_o   = state_q;
  assign set_req_o = filt_hit || (boot_hit && !lvl_i);
endmodule

// File: rtl/cos_flag.sv
module cos_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= set_i | (flag_o & ~clr_i);  // set wins
  end
endmodule

// File: rtl/cts_cos_detector.sv
module cts_cos_detector
  import cts_cos_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_TICKS  = 4,
  parameter int unsigned BOOT_TICKS  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                cts_ni,
  input  logic                rd_i,
  input  logic                irq_en_i,
  input  logic                modem_mode_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                irq_o
);
  logic lvl_sync, state, set_req, flag_set, flag;

  cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cts_ni), .q_o(lvl_sync)
  );

  cts_filter #(.FILT_TICKS(FILT_TICKS), .BOOT_TICKS(BOOT_TICKS)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .lvl_i(lvl_sync),
    .state_o(state), .set_req_o(set_req)
  );

  assign flag_set = set_req && !modem_mode_i;

  cos_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(flag_set), .clr_i(rd_i), .flag_o(flag)
  );

  assign status_o = pack_status(flag, state);
  assign irq_o    = flag && irq_en_i && !modem_mode_i;
endmodule

// File: rtl/cts_cos_chk.sv
module cts_cos_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       rd_i,
  input logic       irq_en_i,
  input logic       modem_mode_i,
  input logic       set_evt,
  input logic [7:0] status_o,
  input logic       irq_o
);
  // R1
  fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:5] == 3'b000 && status_o[3:1] == 3'b111);
  // R3
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[4]) |-> $past(set_evt));
  // R4
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !set_evt) |=> !status_o[4]);
  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt |=> status_o[4]);
  // R7
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o[4] && irq_en_i && !modem_mode_i));
  // R8
  modem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (modem_mode_i && !status_o[4]) |=> !status_o[4]);
  // R9
  lvl_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(status_o[0]));
endmodule

bind cts_cos_detector cts_cos_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rd_i(rd_i),
  .irq_en_i(irq_en_i), .modem_mode_i(modem_mode_i), .set_evt(flag_set),
  .status_o(status_o), .irq_o(irq_o)
);

// File: tb/cts_cos_detector_tb.sv
`timescale 1ns/1ps
module cts_cos_detector_tb;
  localparam int FT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, cts_n = 1, rd = 0, en = 0, modem = 0;
  logic [7:0] status;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  cts_cos_detector #(.FILT_TICKS(FT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cts_ni(cts_n), .rd_i(rd),
    .irq_en_i(en), .modem_mode_i(modem), .status_o(status), .irq_o(irq)
  );

  function automatic logic [7:0] exp_st(input logic f, input logic l);
    return {3'b000, f, 3'b111, l};
  endfunction

  task automatic chk_st(input string req, input logic [7:0] exp);
    n_chk++;
    if (status !== exp) begin
      n_bad++;
      $display("FAIL %s status act=%h exp=%h", req, status, exp);
    end
  endtask

  task automatic chk_irq(input string req, input logic exp);
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s irq act=%b exp=%b", req, irq, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  task automatic do_read();
    @(negedge clk) rd = 1;
    @(negedge clk) rd = 0;
  endtask

  task automatic do_reset(input logic line, input logic mm);
    @(negedge clk) rst_n = 0; cts_n = line; modem = mm;
    wait_clk(2);
    rst_n = 1;
    wait_clk(3);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic base, flg;
    // reset state, line asserted
    do_reset(1'b0, 1'b0);
    chk_st("R2 reset", exp_st(0, 1));
    chk_irq("R7 reset", 0);
    ticks(1);
    chk_st("R6 first tick", exp_st(0, 1));
    ticks(1);
    chk_st("R6 startup asserted", exp_st(1, 0));
    en = 1; wait_clk(1);
    chk_irq("R7 enabled", 1);
    en = 0; wait_clk(1);
    chk_irq("R7 disabled", 0);
    en = 1;
    do_read();
    chk_st("R4 read clears", exp_st(0, 0));
    chk_irq("R7 after read", 0);

    // tick-free hold
    cts_n = 1; wait_clk(10);
    chk_st("R9 no tick", exp_st(0, 0));
    cts_n = 0; wait_clk(3);

    // filter sweep in both directions
    base = 0;
    for (int k = 1; k <= FT + 1; k++) begin
      for (int dir = 0; dir < 2; dir++) begin
        cts_n = ~base; wait_clk(3);
        ticks(k);
        flg = (k >= FT);
        if (flg) base = ~base;
        chk_st("R3 sweep", exp_st(flg, base));
        chk_irq("R7 sweep", flg);
        chk_st("R1 fixed", exp_st(flg, base));
        if (!flg) begin
          cts_n = base; wait_clk(3);
          ticks(1);
          chk_st("R3 glitch dropped", exp_st(0, base));
        end
        do_read();
      end
    end

    // set and read in the same cycle
    cts_n = ~base; wait_clk(3);
    ticks(FT - 1);
    @(negedge clk) tick = 1; rd = 1;
    @(negedge clk) tick = 0; rd = 0;
    base = ~base;
    chk_st("R5 set wins", exp_st(1, base));
    do_read();
    chk_st("R4 clear after", exp_st(0, base));

    // modem mode: level tracks, no flag, no irq
    modem = 1;
    cts_n = ~base; wait_clk(3);
    ticks(FT);
    base = ~base;
    chk_st("R8 modem transition", exp_st(0, base));
    chk_irq("R8 modem irq", 0);
    modem = 0;

    // startup with line negated
    do_reset(1'b1, 1'b0);
    ticks(2);
    chk_st("R6 startup negated", exp_st(0, 1));
    // startup in modem mode, line asserted
    do_reset(1'b0, 1'b1);
    ticks(2);
    chk_st("R8 modem startup", exp_st(0, 0));
    chk_irq("R8 modem startup irq", 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule